// File: doc/BRIEF.md
# Register-Linked Vector Length Unit

This block keeps the active vector length (VL) inside an ordinary integer register rather than in a dedicated status register. A small link register holds the index of the integer register that carries VL. A set-length command clamps a requested length to the hardware maximum (MVL), writes the result to the destination integer register, and links to that register. A fail-on-first report that truncates the element count writes the smaller count straight into the linked register.

The unit watches the integer register-file write port. Any ordinary instruction that writes the linked register changes the effective VL at once, with no transfer instruction in between. A local copy of the linked register's value is updated alongside that write. The VL output is always derived from this local copy, so the unit needs no register-file read port.

The set-length and fail-first inputs and the write-back output are valid/ready streams. A transfer takes place on a clock edge where both valid and ready are high. The unit owns a single write-back slot. While that slot is full and the register file holds `wb_ready` low, the slot stays frozen, and both command streams see ready low. A context-load input sets the link index and the local copy directly, for restoring a saved context. The link index is visible on an output so that it can be saved.

Top module: `vlptr_unit`

## Requirements
- R1: After reset the link index is 0, `vl_o` equals MVL and `wb_valid` is low.
- R2: An accepted set-length command makes `vl_o` equal min(`sv_avl`, MVL) and sets the link index to `sv_rd`. Both are visible in the cycle after acceptance.
- R3: An accepted set-length command with `sv_rd` not 0 presents, in the next cycle, a write-back of the clamped length (zero-extended) to register `sv_rd`. With `sv_rd` = 0 no write-back is produced and the unit becomes unlinked.
- R4: An accepted fail-first report with `ff_count` below the current VL, while linked, sets VL to `ff_count` and presents a write-back of `ff_count` to the linked register in the next cycle.
- R5: An accepted fail-first report with `ff_count` not below the current VL, or while unlinked, changes neither VL nor the write-back port.
- R6: An observed register-file write to the linked register (index not 0) makes `vl_o` equal min(`rf_wdata`, MVL) in the next cycle. Writes to any other index leave VL unchanged.
- R7: Update priority is context load, then set-length, then fail-first, then observed write. `ff_ready` is low while `sv_valid` is high, and both command readies are low while `ctx_we` is high.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_addr` and `wb_data` hold, and `sv_ready` and `ff_ready` are low.
- R9: `vl_ptr_o` reports the link index. A context load sets the link index to `ctx_ptr` and the local copy to `ctx_val`, and produces no write-back.
- R10: While the link index is 0 (unlinked), `vl_o` equals MVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sv_valid | input | 1 | Set-length command valid |
| sv_ready | output | 1 | Set-length command ready |
| sv_avl | input | XW | Requested length |
| sv_rd | input | AW | Destination register index |
| ff_valid | input | 1 | Fail-first report valid |
| ff_ready | output | 1 | Fail-first report ready |
| ff_count | input | VW | Elements completed before the fault |
| rf_we | input | 1 | Observed register-file write enable |
| rf_waddr | input | AW | Observed write index |
| rf_wdata | input | XW | Observed write data |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Register file accepts the write-back |
| wb_addr | output | AW | Write-back register index |
| wb_data | output | XW | Write-back data |
| ctx_we | input | 1 | Context load strobe |
| ctx_ptr | input | AW | Link index to restore |
| ctx_val | input | XW | Value of the restored linked register |
| vl_o | output | VW | Effective vector length |
| vl_ptr_o | output | AW | Current link index |

## Verification
Several rules are checked by assertions on every cycle. These are the MVL bound and the unlinked value of VL, the write-back that follows a set-length command, the truncation by an in-range fail-first report, and the freeze of the write-back slot under back-pressure with the command readies low. The bench scenarios cover the rest. They show the clamping of large requests, fail-first reports that must be ignored, observed writes to linked and unlinked registers, and collisions between set-length and a same-cycle write to the linked register. They also cover context loads and long stretches of random back-pressure, all against a reference model of the link register and the local copy.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  // which event updates the link state in a cycle, highest priority first
  typedef enum logic [2:0] {
    UPD_NONE = 3'd0,
    UPD_CTX  = 3'd1,
    UPD_SET  = 3'd2,
    UPD_FAIL = 3'd3,
    UPD_RF   = 3'd4
  } vlp_src_e;
endpackage

// File: rtl/vlp_clamp.sv
module vlp_clamp #(
  parameter int XW  = 32,
  parameter int MVL = 64,
  localparam int VW = $clog2(MVL + 1)
) (
  input  logic [XW-1:0] value,
  output logic [VW-1:0] clamped
);
  localparam logic [XW-1:0] MVL_X = XW'(MVL);
  localparam logic [VW-1:0] MVL_V = VW'(MVL);

  always_comb begin
    if (value > MVL_X) clamped = MVL_V;
    else               clamped = value[VW-1:0];
  end
endmodule

// File: rtl/vlp_arbiter.sv
module vlp_arbiter
  import vlp_pkg::*;
#(
  parameter int XW   = 32,
  parameter int NREG = 32,
  parameter int MVL  = 64,
  localparam int AW  = $clog2(NREG),
  localparam int VW  = $clog2(MVL + 1)
) (
  input  logic          ctx_we,
  input  logic          sv_valid,
  input  logic [AW-1:0] sv_rd,
  input  logic [VW-1:0] sv_vl,
  input  logic          ff_valid,
  input  logic [VW-1:0] ff_count,
  input  logic          rf_we,
  input  logic [AW-1:0] rf_waddr,
  input  logic [AW-1:0] ptr,
  input  logic [VW-1:0] vl_cur,
  input  logic          wb_free,
  output logic          sv_ready,
  output logic          ff_ready,
  output vlp_src_e      src,
  output logic          wb_load,
  output logic [AW-1:0] wb_load_addr,
  output logic [XW-1:0] wb_load_data
);
  logic linked;
  logic sv_acc;
  logic ff_acc;
  logic ff_hit;
  logic rf_hit;

  assign linked   = (ptr != '0);
  assign sv_ready = wb_free && !ctx_we;
  assign ff_ready = wb_free && !ctx_we && !sv_valid;
  assign sv_acc   = sv_valid && sv_ready;
  assign ff_acc   = ff_valid && ff_ready;
  assign ff_hit   = ff_acc && linked && (ff_count < vl_cur);
  assign rf_hit   = rf_we && linked && (rf_waddr == ptr);

  always_comb begin
    if (ctx_we)      src = UPD_CTX;
    else if (sv_acc) src = UPD_SET;
    else if (ff_hit) src = UPD_FAIL;
    else if (rf_hit) src = UPD_RF;
    else             src = UPD_NONE;
  end

  always_comb begin
    wb_load      = 1'b0;
    wb_load_addr = '0;
    wb_load_data = '0;
    if (src == UPD_SET && sv_rd != '0) begin
      wb_load      = 1'b1;
      wb_load_addr = sv_rd;
      wb_load_data = XW'(sv_vl);
    end else if (src == UPD_FAIL) begin
      wb_load      = 1'b1;
      wb_load_addr = ptr;
      wb_load_data = XW'(ff_count);
    end
  end
endmodule

// File: rtl/vlp_link.sv
module vlp_link
  import vlp_pkg::*;
#(
  parameter int XW   = 32,
  parameter int NREG = 32,
  parameter int MVL  = 64,
  localparam int AW  = $clog2(NREG),
  localparam int VW  = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vlp_src_e      src,
  input  logic [AW-1:0] ctx_ptr,
  input  logic [XW-1:0] ctx_val,
  input  logic [AW-1:0] sv_rd,
  input  logic [VW-1:0] sv_vl,
  input  logic [VW-1:0] ff_count,
  input  logic [XW-1:0] rf_wdata,
  output logic [AW-1:0] ptr,
  output logic [XW-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      shadow <= '0;
    end else begin
      unique case (src)
        UPD_CTX: begin
          ptr    <= ctx_ptr;
          shadow <= ctx_val;
        end
        UPD_SET: begin
          ptr    <= sv_rd;
          shadow <= XW'(sv_vl);
        end
        UPD_FAIL: shadow <= XW'(ff_count);
        UPD_RF:   shadow <= rf_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vlp_wbslot.sv
module vlp_wbslot #(
  parameter int XW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [XW-1:0] load_data,
  input  logic          wb_ready,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [XW-1:0] wb_data,
  output logic          free
);
  assign free = !wb_valid || wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_addr  <= load_addr;
      wb_data  <= load_data;
    end else if (wb_valid && wb_ready) begin
      wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlptr_unit.sv
module vlptr_unit
  import vlp_pkg::*;
#(
  parameter int XW   = 32,
  parameter int NREG = 32,
  parameter int MVL  = 64,
  localparam int AW  = $clog2(NREG),
  localparam int VW  = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sv_valid,
  output logic          sv_ready,
  input  logic [XW-1:0] sv_avl,
  input  logic [AW-1:0] sv_rd,
  input  logic          ff_valid,
  output logic          ff_ready,
  input  logic [VW-1:0] ff_count,
  input  logic          rf_we,
  input  logic [AW-1:0] rf_waddr,
  input  logic [XW-1:0] rf_wdata,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_addr,
  output logic [XW-1:0] wb_data,
  input  logic          ctx_we,
  input  logic [AW-1:0] ctx_ptr,
  input  logic [XW-1:0] ctx_val,
  output logic [VW-1:0] vl_o,
  output logic [AW-1:0] vl_ptr_o
);
  localparam logic [VW-1:0] MVL_V = VW'(MVL);

  vlp_src_e      src;
  logic [VW-1:0] sv_vl;
  logic [VW-1:0] shadow_vl;
  logic [XW-1:0] shadow;
  logic [AW-1:0] ptr;
  logic          wb_free;
  logic          wb_load;
  logic [AW-1:0] wb_load_addr;
  logic [XW-1:0] wb_load_data;

  vlp_clamp #(.XW(XW), .MVL(MVL)) u_req_clamp (.value(sv_avl), .clamped(sv_vl));
  vlp_clamp #(.XW(XW), .MVL(MVL)) u_cur_clamp (.value(shadow), .clamped(shadow_vl));

  // unlinked means the full hardware length
  assign vl_o     = (ptr == '0) ? MVL_V : shadow_vl;
  assign vl_ptr_o = ptr;

  vlp_arbiter #(.XW(XW), .NREG(NREG), .MVL(MVL)) u_arb (
    .ctx_we      (ctx_we),
    .sv_valid    (sv_valid),
    .sv_rd       (sv_rd),
    .sv_vl       (sv_vl),
    .ff_valid    (ff_valid),
    .ff_count    (ff_count),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .ptr         (ptr),
    .vl_cur      (vl_o),
    .wb_free     (wb_free),
    .sv_ready    (sv_ready),
    .ff_ready    (ff_ready),
    .src         (src),
    .wb_load     (wb_load),
    .wb_load_addr(wb_load_addr),
    .wb_load_data(wb_load_data)
  );

  vlp_link #(.XW(XW), .NREG(NREG), .MVL(MVL)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src),
    .ctx_ptr (ctx_ptr),
    .ctx_val (ctx_val),
    .sv_rd   (sv_rd),
    .sv_vl   (sv_vl),
    .ff_count(ff_count),
    .rf_wdata(rf_wdata),
    .ptr     (ptr),
    .shadow  (shadow)
  );

  vlp_wbslot #(.XW(XW), .NREG(NREG)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wb_load),
    .load_addr(wb_load_addr),
    .load_data(wb_load_data),
    .wb_ready (wb_ready),
    .wb_valid (wb_valid),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .free     (wb_free)
  );
endmodule

// File: rtl/vlptr_unit_chk.sv
module vlptr_unit_chk #(
  parameter int XW   = 32,
  parameter int NREG = 32,
  parameter int MVL  = 64,
  localparam int AW  = $clog2(NREG),
  localparam int VW  = $clog2(MVL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sv_valid,
  input logic          sv_ready,
  input logic [AW-1:0] sv_rd,
  input logic          ff_valid,
  input logic          ff_ready,
  input logic [VW-1:0] ff_count,
  input logic          rf_we,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [AW-1:0] wb_addr,
  input logic [XW-1:0] wb_data,
  input logic [VW-1:0] vl_o,
  input logic [AW-1:0] vl_ptr_o
);
  localparam logic [VW-1:0] MVL_V = VW'(MVL);

  // R10
  unlinked_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_ptr_o == '0) |-> (vl_o == MVL_V));

  // R2
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= MVL_V);

  // R3
  set_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_valid && sv_ready && sv_rd != '0) |=>
      (wb_valid && wb_addr == $past(sv_rd) && vl_ptr_o == $past(sv_rd) && wb_data == XW'(vl_o)));

  // R4
  ff_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_valid && ff_ready && vl_ptr_o != '0 && ff_count < vl_o) |=>
      (vl_o == $past(ff_count) && wb_valid && wb_addr == vl_ptr_o));

  // R5
  ff_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_valid && ff_ready && ff_count >= vl_o && !rf_we) |=> $stable(vl_o));

  // R7
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_valid |-> !ff_ready);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |-> (!sv_ready && !ff_ready));
endmodule

bind vlptr_unit vlptr_unit_chk #(.XW(XW), .NREG(NREG), .MVL(MVL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sv_valid(sv_valid),
  .sv_ready(sv_ready),
  .sv_rd   (sv_rd),
  .ff_valid(ff_valid),
  .ff_ready(ff_ready),
  .ff_count(ff_count),
  .rf_we   (rf_we),
  .wb_valid(wb_valid),
  .wb_ready(wb_ready),
  .wb_addr (wb_addr),
  .wb_data (wb_data),
  .vl_o    (vl_o),
  .vl_ptr_o(vl_ptr_o)
);

// File: tb/test_vlptr_unit.sv
module test_vlptr_unit;
  localparam int XW = 32, NREG = 32, MVL = 64;
  localparam int AW = $clog2(NREG);
  localparam int VW = $clog2(MVL + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sv_valid, sv_ready, ff_valid, ff_ready, rf_we;
  logic wb_valid, wb_ready, ctx_we;
  logic [XW-1:0] sv_avl, rf_wdata, wb_data, ctx_val;
  logic [AW-1:0] sv_rd, rf_waddr, wb_addr, ctx_ptr, vl_ptr_o;
  logic [VW-1:0] ff_count, vl_o;

  vlptr_unit #(.XW(XW), .NREG(NREG), .MVL(MVL)) i_vlptr_unit (
    .clk(clk), .rst_n(rst_n),
    .sv_valid(sv_valid), .sv_ready(sv_ready), .sv_avl(sv_avl), .sv_rd(sv_rd),
    .ff_valid(ff_valid), .ff_ready(ff_ready), .ff_count(ff_count),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .ctx_we(ctx_we), .ctx_ptr(ctx_ptr), .ctx_val(ctx_val),
    .vl_o(vl_o), .vl_ptr_o(vl_ptr_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [AW-1:0] m_ptr = '0;
  logic [XW-1:0] m_lat = '0;
  logic          m_wbv = 1'b0;
  logic [AW-1:0] m_wba = '0;
  logic [XW-1:0] m_wbd = '0;

  function automatic logic [VW-1:0] clampv(logic [XW-1:0] v);
    return (v > XW'(MVL)) ? VW'(MVL) : v[VW-1:0];
  endfunction

  function automatic logic [VW-1:0] model_vl();
    return (m_ptr == '0) ? VW'(MVL) : clampv(m_lat);
  endfunction

  task automatic chk(string tag, logic [XW-1:0] act, logic [XW-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    sv_valid = 0; sv_avl = '0; sv_rd = '0;
    ff_valid = 0; ff_count = '0;
    rf_we = 0; rf_waddr = '0; rf_wdata = '0;
    ctx_we = 0; ctx_ptr = '0; ctx_val = '0;
    wb_ready = 1;
  endtask

  // inputs were driven at a falling edge; check readies, advance model, check outputs
  task automatic step(string tag);
    logic free, sva, ffa, ffhit;
    #1;
    free = !m_wbv || wb_ready;
    sva  = sv_valid && free && !ctx_we;
    ffa  = ff_valid && free && !ctx_we && !sv_valid;
    chk("R8", XW'(sv_ready), XW'(free && !ctx_we), "sv_ready");
    chk("R7", XW'(ff_ready), XW'(free && !ctx_we && !sv_valid), "ff_ready");
    ffhit = ffa && (m_ptr != '0) && (ff_count < model_vl());
    if (sva && sv_rd != '0) begin
      m_wbv = 1; m_wba = sv_rd; m_wbd = XW'(clampv(sv_avl));
    end else if (ffhit) begin
      m_wbv = 1; m_wba = m_ptr; m_wbd = XW'(ff_count);
    end else if (m_wbv && wb_ready) begin
      m_wbv = 0;
    end
    if (ctx_we) begin
      m_ptr = ctx_ptr; m_lat = ctx_val;
    end else if (sva) begin
      m_ptr = sv_rd; m_lat = XW'(clampv(sv_avl));
    end else if (ffhit) begin
      m_lat = XW'(ff_count);
    end else if (rf_we && rf_waddr == m_ptr && m_ptr != '0) begin
      m_lat = rf_wdata;
    end
    @(posedge clk); #1;
    chk(tag, XW'(vl_o), XW'(model_vl()), "vl_o");
    chk("R9", XW'(vl_ptr_o), XW'(m_ptr), "vl_ptr_o");
    chk(tag, XW'(wb_valid), XW'(m_wbv), "wb_valid");
    if (m_wbv) begin
      chk(tag, XW'(wb_addr), XW'(m_wba), "wb_addr");
      chk(tag, wb_data, m_wbd, "wb_data");
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", XW'(vl_o), XW'(MVL), "vl_o");
    chk("R1", XW'(vl_ptr_o), '0, "vl_ptr_o");
    chk("R1", XW'(wb_valid), '0, "wb_valid");
    rst_n = 1;

    // R10 unlinked fail-first is ignored (R5)
    @(negedge clk); idle(); ff_valid = 1; ff_count = 7'd3; step("R5");
    // R2 request above MVL clamps
    @(negedge clk); idle(); sv_valid = 1; sv_avl = 200; sv_rd = 5; step("R2");
    // R3 small request, write-back to rd
    @(negedge clk); idle(); sv_valid = 1; sv_avl = 10; sv_rd = 7; step("R3");
    // R4 fail-first truncates
    @(negedge clk); idle(); ff_valid = 1; ff_count = 7'd4; step("R4");
    // R5 fail-first not below VL ignored
    @(negedge clk); idle(); ff_valid = 1; ff_count = 7'd9; step("R5");
    @(negedge clk); idle(); ff_valid = 1; ff_count = 7'd4; step("R5");
    // R6 writes to other and linked registers
    @(negedge clk); idle(); rf_we = 1; rf_waddr = 3; rf_wdata = 2; step("R6");
    @(negedge clk); idle(); rf_we = 1; rf_waddr = 7; rf_wdata = 30; step("R6");
    @(negedge clk); idle(); rf_we = 1; rf_waddr = 7; rf_wdata = 1000; step("R6");
    // R7 set-length beats same-cycle linked write
    @(negedge clk); idle(); sv_valid = 1; sv_avl = 12; sv_rd = 7;
    rf_we = 1; rf_waddr = 7; rf_wdata = 50; step("R7");
    // R7 fail-first beats same-cycle linked write
    @(negedge clk); idle(); ff_valid = 1; ff_count = 7'd2;
    rf_we = 1; rf_waddr = 7; rf_wdata = 40; step("R7");
    // R7 set-length and fail-first together
    @(negedge clk); idle(); sv_valid = 1; sv_avl = 20; sv_rd = 9;
    ff_valid = 1; ff_count = 7'd1; step("R7");
    // R8 back-pressure
    @(negedge clk); idle(); wb_ready = 0; sv_valid = 1; sv_avl = 33; sv_rd = 4; step("R8");
    @(negedge clk); idle(); wb_ready = 0; sv_valid = 1; sv_avl = 5; sv_rd = 6; step("R8");
    @(negedge clk); idle(); wb_ready = 0; ff_valid = 1; ff_count = 7'd1; step("R8");
    @(negedge clk); idle(); step("R8");
    // R9 context load, wins over set-length
    @(negedge clk); idle(); ctx_we = 1; ctx_ptr = 9; ctx_val = 17;
    sv_valid = 1; sv_avl = 3; sv_rd = 2; step("R9");
    // R10 context load to unlinked
    @(negedge clk); idle(); ctx_we = 1; ctx_ptr = 0; ctx_val = 5; step("R10");
    @(negedge clk); idle(); rf_we = 1; rf_waddr = 0; rf_wdata = 3; step("R10");
    // R3 destination 0 unlinks, no write-back
    @(negedge clk); idle(); sv_valid = 1; sv_avl = 8; sv_rd = 0; step("R3");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      string tag;
      @(negedge clk); idle();
      wb_ready = ($urandom % 10) < 7;
      sv_valid = ($urandom % 6) == 0;
      sv_avl   = ($urandom % 2) ? XW'($urandom % 100) : $urandom;
      sv_rd    = AW'($urandom % 8);
      ff_valid = ($urandom % 4) == 0;
      ff_count = VW'($urandom % (MVL + 6));
      rf_we    = ($urandom % 3) == 0;
      rf_waddr = ($urandom % 2) ? m_ptr : AW'($urandom % 8);
      rf_wdata = ($urandom % 2) ? XW'($urandom % 80) : $urandom;
      ctx_we   = ($urandom % 40) == 0;
      ctx_ptr  = AW'($urandom % 8);
      ctx_val  = XW'($urandom % 90);
      tag = ctx_we ? "R9" : sv_valid ? "R2" : ff_valid ? "R4" : "R6";
      step(tag);
    end

    summary();
    $finish;
  end
endmodule